// File: doc/BRIEF.md
# Sticky Status Alert Controller

This block gathers out-of-limit flags that upstream monitoring logic has already compared against their limits. It holds each flag in a latched ("sticky") status bit and drives an active-low alert line to a host. There are sixteen sources in two banks. The first bank takes eight generic condition inputs. The second bank takes two remote-sensor open/short faults, four fan under-speed flags, an over-temperature flag and a thermal-timer limit flag. The fourth fan flag and the timer flag share one status position, and a configuration input picks which one drives it.

A status bit sets as soon as its condition is seen. It clears only when two things are both true: the host has read its register, and the condition was already absent at that read. Two mask registers let the host keep single sources from pulling the alert low. Masking does not change how the status bits set or clear. The usual host flow is as follows. On an alert, the host reads status, masks the source, and handles the event. It then polls until the status bit has cleared, and finally clears the mask to re-arm that source.

The host port is a plain register port that accepts every access at once. It has no handshake and no back-pressure. A read returns data in the same cycle as the read strobe. A write or a read side effect takes hold at the next rising clock edge.

Top module: `alert_status_ctrl`

## Requirements
- R1: A status bit reads 1 from the clock edge after its condition input is seen high. Status register 1 (address 0x41) holds `gen_cond` bit for bit.
- R2: A read strobe to a status register replaces each bit of it, at the next edge, with the condition value sampled in the read cycle. A bit whose condition is still high (or newly high) stays 1. A bit whose condition is low clears. Without such a read a set bit stays set.
- R3: `alert_n` is driven by a register. It goes low at the edge where any unmasked status bit is or becomes set. It stays low until every set status bit is masked or cleared. It is therefore low while an unmasked condition persists and until that status has been read after the condition has gone.
- R4: A mask bit of 1 keeps its source from pulling `alert_n` low. The matching status bit still sets and clears exactly as in R1 and R2.
- R5: After a status bit has cleared, writing its mask bit back to 0 leaves `alert_n` high. A later event on that source pulls `alert_n` low again.
- R6: Status register 2 (address 0x42) layout: bit 7 is remote sensor 2 fault, bit 6 is remote sensor 1 fault, bit 5 is the shared fan-4/timer flag, bits 4, 3 and 2 are fans 3, 2 and 1 under-speed, bit 1 is over-temperature, and bit 0 always reads 0.
- R7: With `bit5_timer_sel` = 1, status bit 5 follows `timer_lim` and ignores `fan_slow[3]`. With 0 it follows `fan_slow[3]` and ignores `timer_lim`.
- R8: Mask register 1 (0x74) masks status register 1 bit for bit. Mask register 2 (0x75) masks status register 2 bit for bit. Both are written at the edge of the write strobe and read back what was written.
- R9: Writes to 0x41 or 0x42 change no status bit.
- R10: After reset all status bits and mask bits are 0, and `alert_n` is 1.
- R11: A read of any address other than 0x41, 0x42, 0x74 and 0x75 returns 0x00 and clears no status bit.
- R12: `reg_rdata` shows the addressed register's current value combinationally, in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one access per cycle high |
| reg_rd | input | 1 | Read strobe, one access per cycle high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| gen_cond | input | 8 | Generic condition flags for status register 1 |
| rsens_fault | input | 2 | Remote sensor open/short faults, [0]=sensor 1, [1]=sensor 2 |
| fan_slow | input | 4 | Fan under-speed flags, [0]=fan 1 ... [3]=fan 4 |
| overtemp | input | 1 | Over-temperature limit flag |
| timer_lim | input | 1 | Thermal-timer limit flag |
| bit5_timer_sel | input | 1 | Selects timer (1) or fan 4 (0) for status bit 5 |
| alert_n | output | 1 | Alert to host, active low |

## Verification
Read data is combinational, so the bench drives the address and strobe just after a falling edge and samples `reg_rdata` 1 ns later, before the next rising edge. Status set, read clear and mask writes all land at the next rising edge. `alert_n` is registered from the next-state status and mask, so it also moves at that same edge. The bench updates its reference model at the rising edge and compares `alert_n` at the falling edge after it. Each status read therefore checks the model state from before the edge that applies the read's clear.

// File: rtl/asa_pkg.sv
`timescale 1ns/1ps
package asa_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 8;
  localparam int unsigned NUM_FAN = 4;
  localparam int unsigned NUM_RS  = 2;
  localparam int unsigned NBANK   = 2;

  localparam logic [AW-1:0] ADDR_STAT1 = 8'h41;
  localparam logic [AW-1:0] ADDR_STAT2 = 8'h42;
  localparam logic [AW-1:0] ADDR_MASK1 = 8'h74;
  localparam logic [AW-1:0] ADDR_MASK2 = 8'h75;

  // status register 2 bit positions (host software decodes these)
  localparam int unsigned B_OVT   = 1;
  localparam int unsigned B_FAN0  = 2;
  localparam int unsigned B_SHARE = 5;
  localparam int unsigned B_RS0   = 6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT1,
    SEL_STAT2,
    SEL_MASK1,
    SEL_MASK2
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
    reg_sel_e s;
    case (a)
      ADDR_STAT1: s = SEL_STAT1;
      ADDR_STAT2: s = SEL_STAT2;
      ADDR_MASK1: s = SEL_MASK1;
      ADDR_MASK2: s = SEL_MASK2;
      default:    s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/asa_cond_pack.sv
`timescale 1ns/1ps
module asa_cond_pack
  import asa_pkg::*;
(
  input  logic [NUM_RS-1:0]  rsens_fault,
  input  logic [NUM_FAN-1:0] fan_slow,
  input  logic               overtemp,
  input  logic               timer_lim,
  input  logic               bit5_timer_sel,
  output logic [DW-1:0]      cond
);
  localparam int unsigned NFAN_DIRECT = NUM_FAN - 1;

  logic shared_flag;
  assign shared_flag = bit5_timer_sel ? timer_lim : fan_slow[NUM_FAN-1];

  assign cond[0]       = 1'b0;
  assign cond[B_OVT]   = overtemp;
  assign cond[B_SHARE] = shared_flag;

  for (genvar f = 0; f < NFAN_DIRECT; f++) begin : g_fan
    assign cond[B_FAN0+f] = fan_slow[f];
  end

  for (genvar r = 0; r < NUM_RS; r++) begin : g_rs
    assign cond[B_RS0+r] = rsens_fault[r];
  end
endmodule

// File: rtl/asa_sticky_bank.sv
`timescale 1ns/1ps
module asa_sticky_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         rd_hit,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_nxt
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic nxt;
    logic q;
    // read replaces the bit with the sampled condition; otherwise accumulate
    always_comb nxt = rd_hit ? cond[i] : (q | cond[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
    end
    assign stat_q[i]   = q;
    assign stat_nxt[i] = nxt;
  end
endmodule

// File: rtl/asa_mask_reg.sv
`timescale 1ns/1ps
module asa_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_nxt
);
  always_comb mask_nxt = wr_en ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/asa_alert_drv.sv
`timescale 1ns/1ps
module asa_alert_drv #(
  parameter int unsigned W     = 8,
  parameter int unsigned NSRC  = 2,
  localparam int unsigned TOT  = W * NSRC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TOT-1:0] stat_nxt,
  input  logic [TOT-1:0] mask_nxt,
  output logic           alert_n
);
  logic any_live;
  assign any_live = |(stat_nxt & ~mask_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= ~any_live;
  end
endmodule

// File: rtl/alert_status_ctrl.sv
`timescale 1ns/1ps
module alert_status_ctrl
  import asa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic [DW-1:0]      gen_cond,
  input  logic [NUM_RS-1:0]  rsens_fault,
  input  logic [NUM_FAN-1:0] fan_slow,
  input  logic               overtemp,
  input  logic               timer_lim,
  input  logic               bit5_timer_sel,
  output logic               alert_n
);
  reg_sel_e      sel;
  logic [DW-1:0] st2_cond;
  logic [DW-1:0] stat1_q, stat1_nxt, stat2_q, stat2_nxt;
  logic [DW-1:0] mask1_q, mask1_nxt, mask2_q, mask2_nxt;

  assign sel = decode_addr(reg_addr);

  asa_cond_pack u_pack (
    .rsens_fault   (rsens_fault),
    .fan_slow      (fan_slow),
    .overtemp      (overtemp),
    .timer_lim     (timer_lim),
    .bit5_timer_sel(bit5_timer_sel),
    .cond          (st2_cond)
  );

  asa_sticky_bank #(.W(DW)) u_bank1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (gen_cond),
    .rd_hit  (reg_rd && (sel == SEL_STAT1)),
    .stat_q  (stat1_q),
    .stat_nxt(stat1_nxt)
  );

  asa_sticky_bank #(.W(DW)) u_bank2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond    (st2_cond),
    .rd_hit  (reg_rd && (sel == SEL_STAT2)),
    .stat_q  (stat2_q),
    .stat_nxt(stat2_nxt)
  );

  asa_mask_reg #(.W(DW)) u_mask1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && (sel == SEL_MASK1)),
    .wdata   (reg_wdata),
    .mask_q  (mask1_q),
    .mask_nxt(mask1_nxt)
  );

  asa_mask_reg #(.W(DW)) u_mask2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr && (sel == SEL_MASK2)),
    .wdata   (reg_wdata),
    .mask_q  (mask2_q),
    .mask_nxt(mask2_nxt)
  );

  asa_alert_drv #(.W(DW), .NSRC(NBANK)) u_alert (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_nxt({stat2_nxt, stat1_nxt}),
    .mask_nxt({mask2_nxt, mask1_nxt}),
    .alert_n (alert_n)
  );

  always_comb begin
    case (sel)
      SEL_STAT1: reg_rdata = stat1_q;
      SEL_STAT2: reg_rdata = stat2_q;
      SEL_MASK1: reg_rdata = mask1_q;
      SEL_MASK2: reg_rdata = mask2_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/alert_status_chk.sv
`timescale 1ns/1ps
module alert_status_chk
  import asa_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] c1,
  input logic [DW-1:0] c2,
  input logic [DW-1:0] st1,
  input logic [DW-1:0] st2,
  input logic [DW-1:0] m1,
  input logic [DW-1:0] m2,
  input logic          alert_n
);
  logic rd1, mapped;
  assign rd1    = reg_rd && (reg_addr == ADDR_STAT1);
  assign mapped = (reg_addr == ADDR_STAT1) || (reg_addr == ADDR_STAT2) ||
                  (reg_addr == ADDR_MASK1) || (reg_addr == ADDR_MASK2);

  assert_set_on_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|c1) |=> ((st1 & $past(c1)) == $past(c1)));

  assert_read_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 |=> (st1 == $past(c1)));

  assert_hold_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd1 |=> ((st1 & $past(st1)) == $past(st1)));

  assert_alert_tracks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alert_n == (((st1 & ~m1) == '0) && ((st2 & ~m2) == '0)));

  assert_stat2_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st2[0] == 1'b0);

  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_MASK2) |=> (m2 == $past(reg_wdata)));

  assert_stat_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_STAT2 && c2 == '0) |=> ((st2 & ~$past(st2)) == '0));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |-> (reg_rdata == '0));
endmodule

bind alert_status_ctrl alert_status_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .c1       (gen_cond),
  .c2       (st2_cond),
  .st1      (stat1_q),
  .st2      (stat2_q),
  .m1       (mask1_q),
  .m2       (mask2_q),
  .alert_n  (alert_n)
);

// File: tb/tb_alert_status_ctrl.sv
`timescale 1ns/1ps
module tb_alert_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [7:0] gen_cond = 8'h00;
  logic [1:0] rsens_fault = 2'b00;
  logic [3:0] fan_slow = 4'h0;
  logic       overtemp = 1'b0, timer_lim = 1'b0, bit5_timer_sel = 1'b0;
  logic       alert_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mst1 = 0, mst2 = 0, mm1 = 0, mm2 = 0;
  logic       malert_n = 1'b1;

  always #2 clk = ~clk;

  alert_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_cond(gen_cond),
    .rsens_fault(rsens_fault), .fan_slow(fan_slow), .overtemp(overtemp),
    .timer_lim(timer_lim), .bit5_timer_sel(bit5_timer_sel), .alert_n(alert_n)
  );

  function automatic logic [7:0] exp_c2();
    return {rsens_fault[1], rsens_fault[0], (bit5_timer_sel ? timer_lim : fan_slow[3]),
            fan_slow[2], fan_slow[1], fan_slow[0], overtemp, 1'b0};
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    case (a)
      8'h41: return mst1;
      8'h42: return mst2;
      8'h74: return mm1;
      8'h75: return mm2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] c1, c2, n1, n2, nm1, nm2;
    c1 = gen_cond; c2 = exp_c2();
    n1 = (reg_rd && reg_addr == 8'h41) ? c1 : (mst1 | c1);
    n2 = (reg_rd && reg_addr == 8'h42) ? c2 : (mst2 | c2);
    nm1 = (reg_wr && reg_addr == 8'h74) ? reg_wdata : mm1;
    nm2 = (reg_wr && reg_addr == 8'h75) ? reg_wdata : mm2;
    mst1 = n1; mst2 = n2; mm1 = nm1; mm2 = nm2;
    malert_n = ~|((n1 & ~nm1) | (n2 & ~nm2));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3 alert vs model", {7'd0, alert_n}, {7'd0, malert_n});
    reg_rd = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a; reg_rd = 1'b1;
    #1 chk(req, reg_rdata, exp);
    chk({req, " model"}, reg_rdata, exp_read(a));
    tick();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 alert reset high", {7'd0, alert_n}, 8'h01);
    rd_lit(8'h41, 8'h00, "R10 stat1 reset");
    rd_lit(8'h42, 8'h00, "R10 stat2 reset");
    rd_lit(8'h74, 8'h00, "R10 mask1 reset");
    rd_lit(8'h75, 8'h00, "R10 mask2 reset");

    // R1 set, R3 alert, R2 clear after condition gone
    gen_cond = 8'h05; tick(); gen_cond = 8'h00;
    chk("R3 alert low after event", {7'd0, alert_n}, 8'h00);
    tick();
    chk("R3 alert held after condition gone", {7'd0, alert_n}, 8'h00);
    rd_lit(8'h41, 8'h05, "R1 stat1 set");
    chk("R3 alert released after read", {7'd0, alert_n}, 8'h01);
    rd_lit(8'h41, 8'h00, "R2 stat1 cleared");

    // R2 read with condition still present keeps bit; R6 position
    overtemp = 1'b1; tick();
    rd_lit(8'h42, 8'h02, "R6 overtemp bit1");
    rd_lit(8'h42, 8'h02, "R2 kept while present");
    overtemp = 1'b0;
    rd_lit(8'h42, 8'h02, "R2 read at drop keeps till next read");
    rd_lit(8'h42, 8'h00, "R2 cleared");
    // condition arriving with read keeps bit
    reg_addr = 8'h42; reg_rd = 1'b1; overtemp = 1'b1; tick(); overtemp = 1'b0;
    rd_lit(8'h42, 8'h02, "R2 arrival in read cycle keeps");
    rd_lit(8'h42, 8'h00, "R2 cleared again");

    // R6 layout
    rsens_fault = 2'b10; fan_slow = 4'b0001; tick(); rsens_fault = 0; fan_slow = 0;
    rd_lit(8'h42, 8'h84, "R6 rs2 bit7 fan1 bit2");
    rsens_fault = 2'b01; fan_slow = 4'b0110; tick(); rsens_fault = 0; fan_slow = 0;
    rd_lit(8'h42, 8'h58, "R6 rs1 bit6 fan3/fan2 bits4,3");
    rd_lit(8'h42, 8'h00, "R6 cleared");

    // R7 bit5 select
    bit5_timer_sel = 1'b1; fan_slow = 4'b1000; tick(); fan_slow = 0;
    rd_lit(8'h42, 8'h00, "R7 fan4 ignored with timer select");
    timer_lim = 1'b1; tick(); timer_lim = 0;
    rd_lit(8'h42, 8'h20, "R7 timer on bit5");
    bit5_timer_sel = 1'b0; timer_lim = 1'b1; tick(); timer_lim = 0;
    rd_lit(8'h42, 8'h00, "R7 timer ignored with fan select");
    fan_slow = 4'b1000; tick(); fan_slow = 0;
    rd_lit(8'h42, 8'h20, "R7 fan4 on bit5");
    rd_lit(8'h42, 8'h00, "R7 cleared");

    // R4 masking, R8 mask regs, R5 re-arm
    wr(8'h75, 8'h02);
    rd_lit(8'h75, 8'h02, "R8 mask2 readback");
    overtemp = 1'b1; tick(); overtemp = 1'b0;
    chk("R4 masked source no alert", {7'd0, alert_n}, 8'h01);
    rd_lit(8'h42, 8'h02, "R4 status still sets");
    rd_lit(8'h42, 8'h00, "R4 status clears normally");
    wr(8'h75, 8'h00);
    chk("R5 unmask after clear keeps alert high", {7'd0, alert_n}, 8'h01);
    overtemp = 1'b1; tick(); overtemp = 1'b0;
    chk("R5 re-armed alert", {7'd0, alert_n}, 8'h00);
    rd_lit(8'h42, 8'h02, "R5 status");
    wr(8'h74, 8'h10);
    gen_cond = 8'h10; tick(); gen_cond = 0;
    chk("R8 mask1 maps stat1 bit4", {7'd0, alert_n}, 8'h01);
    rd_lit(8'h41, 8'h10, "R8 stat1 set under mask");
    rd_lit(8'h41, 8'h00, "R8 stat1 clear");
    wr(8'h74, 8'h00);

    // R9 writes to status ignored
    wr(8'h41, 8'hFF); wr(8'h42, 8'hFF);
    rd_lit(8'h41, 8'h00, "R9 stat1 write ignored");
    rd_lit(8'h42, 8'h00, "R9 stat2 write ignored");

    // R11 unmapped read no side effect, R12 combinational
    gen_cond = 8'h80; tick(); gen_cond = 0;
    rd_lit(8'h40, 8'h00, "R11 unmapped zero");
    rd_lit(8'hFF, 8'h00, "R11 unmapped zero high");
    rd_lit(8'h41, 8'h80, "R11 no clear by unmapped read; R12 same cycle");
    rd_lit(8'h41, 8'h00, "R2 cleared");

    // constrained random
    void'($urandom(32'd20240917));
    for (int it = 0; it < 4000; it++) begin
      int op;
      if ($urandom_range(3) == 0) begin
        gen_cond    = 8'($urandom & $urandom & $urandom);
        rsens_fault = 2'($urandom & $urandom);
        fan_slow    = 4'($urandom & $urandom & $urandom);
        overtemp    = ($urandom_range(7) == 0);
        timer_lim   = ($urandom_range(7) == 0);
      end
      if ($urandom_range(63) == 0) bit5_timer_sel = ~bit5_timer_sel;
      op = $urandom_range(7);
      case (op)
        0, 1: begin reg_addr = 8'h41; reg_rd = 1'b1; end
        2:    begin reg_addr = 8'h42; reg_rd = 1'b1; end
        3:    begin reg_addr = $urandom_range(1) ? 8'h74 : 8'h75; reg_rd = 1'b1; end
        4:    begin reg_addr = $urandom_range(1) ? 8'h74 : 8'h75; reg_wr = 1'b1;
                    reg_wdata = 8'($urandom & $urandom); end
        5:    begin reg_addr = $urandom_range(1) ? 8'h41 : 8'h42; reg_wr = 1'b1;
                    reg_wdata = 8'($urandom); end
        6:    begin reg_addr = 8'(8'h43 + $urandom_range(47)); reg_rd = 1'b1; end
        default: ;
      endcase
      if (reg_rd) begin
        #1 chk("R1/R2/R6/R8/R11 random read", reg_rdata, exp_read(reg_addr));
      end
      tick();
    end

    finish_run();
  end
endmodule